// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Alarm

This block keeps time for a system that spends most of its life asleep. A 47-bit counter advances once per slow-domain tick, which is a one-cycle enable pulse on the bus clock. The upper 32 bits of the counter form a whole-seconds value and the lower 15 bits count sub-second ticks. Software sees the counter as two 32-bit registers. One holds the low word of the count. The other holds the remaining high bits.

A 32-bit alarm value is compared against the seconds field. When the two are equal and the alarm is armed, a sticky status flag is raised. That flag, gated by the alarm enable and the wake-up enable, drives a registered interrupt and wake request line.

Control writes are staged before they take effect. They pass through a two-flop synchroniser and one more tick-enabled stage before they reach the slow domain. The control register reads back this synchronised state, so software can poll it to learn when a change has landed. The counter can only be loaded while it is stopped, and the alarm can only be loaded while it is disarmed.

Top module: `rtc_lp_top`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and the counter stays at zero while ticks arrive.
- R2: The control register is at offset 0x04. Bit 0 runs the counter, bit 1 arms the alarm, and bit 3 enables wake-up. A written value takes effect on the third tick after the write, and the register reads back the value that has taken effect, not the value last written.
- R3: While the run bit is in effect, the counter adds one on every tick. Offset 0x20 reads counter bits 31:0 and offset 0x1C reads counter bits 46:32 in bits 14:0 of the word. A carry out of the low word appears in the high register.
- R4: Writes to offsets 0x1C and 0x20 load the counter only while the run bit in effect is clear; otherwise they are ignored.
- R5: The alarm register is at offset 0x24. It is 32 bits wide and takes a write only while the alarm-arm bit in effect is clear.
- R6: When the alarm is armed and counter bits 46:15 equal the alarm value, status bit 0 at offset 0x18 reads 1 from the second bus cycle after the tick that made them equal. It stays 0 while the seconds field is still one below the alarm value.
- R7: Status bit 0 stays set until bit 0 of a write to offset 0x18 is 1, and a write of all ones also clears it. Writing 0 to that bit has no effect. While the match still holds, the match wins over a clear.
- R8: While the alarm-arm bit in effect is clear, equal seconds and alarm values do not set the status flag.
- R9: `irq` is the registered AND of the status flag, the alarm-arm bit in effect, and the wake-up bit in effect.
- R10: While the counter runs, a reader that reads the high register and then the low register twice, and repeats until both pairs agree, gets a value that lies between the counts before and after the read and never goes backwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per slow-clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Alarm interrupt and wake request |

## Verification
The bench builds the block with its default parameters: a 15-bit sub-second field, 32-bit data, and two synchroniser flops plus one active stage. Waiting for whole seconds at that width would take tens of thousands of ticks. Instead, the bench loads the counter while it is stopped, to just below a seconds boundary or just below a low-word carry. This brings the alarm match, the carry between the two counter registers, and torn two-register reads within a few dozen ticks. Ticks are pulsed by hand, so the exact three-tick staging of control changes can be checked to the tick.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  localparam int DATA_W = 32;

  // Register byte offsets; software depends on these.
  localparam logic [7:0] OFF_CTRL   = 8'h04;
  localparam logic [7:0] OFF_STAT   = 8'h18;
  localparam logic [7:0] OFF_CNT_HI = 8'h1C;
  localparam logic [7:0] OFF_CNT_LO = 8'h20;
  localparam logic [7:0] OFF_ALARM  = 8'h24;

  // Control word bit positions.
  localparam int CB_RUN   = 0;
  localparam int CB_ARM   = 1;
  localparam int CB_WAKE  = 3;
  localparam int CB_FLAG  = 0;

  typedef struct packed {
    logic wake;
    logic arm;
    logic run;
  } rtc_ctrl_t;
endpackage

// File: rtl/rtc_lp_sync.sv
// Tick-enabled staging of control bits into the slow domain:
// NFLOPS synchroniser stages followed by one active stage.
module rtc_lp_sync #(
  parameter int W      = 3,
  parameter int NFLOPS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NST = NFLOPS + 1;

  logic [NST-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else if (tick) begin
      chain[0] <= d;
      for (int i = 1; i < NST; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[NST-1];
endmodule

// File: rtl/rtc_lp_counter.sv
// Free-running seconds/sub-second counter with load ports.
module rtc_lp_counter #(
  parameter int DATA_W = 32,
  parameter int SUB_W  = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic                     run,
  input  logic                     ld_lo,
  input  logic                     ld_hi,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W+SUB_W-1:0]  cnt,
  output logic [DATA_W-1:0]        seconds
);
  localparam int CNT_W = DATA_W + SUB_W;
  localparam int HI_W  = CNT_W - DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (run) begin
      if (tick) cnt <= cnt + CNT_W'(1);
    end else begin
      if (ld_lo) cnt[DATA_W-1:0]     <= wdata;
      if (ld_hi) cnt[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
    end
  end

  assign seconds = cnt[CNT_W-1:SUB_W];
endmodule

// File: rtl/rtc_lp_alarm.sv
// Alarm value, seconds compare, sticky flag and gated interrupt.
module rtc_lp_alarm #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] seconds,
  input  logic              arm,
  input  logic              wake,
  input  logic              ld_alarm,
  input  logic              clr_flag,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] alarm_val,
  output logic              flag,
  output logic              irq
);
  logic hit;

  assign hit = arm && (seconds == alarm_val);

  always_ff @(posedge clk) begin
    if (rst)                  alarm_val <= '0;
    else if (ld_alarm && !arm) alarm_val <= wdata;
  end

  // A live match takes priority over a software clear.
  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (clr_flag) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag && arm && wake;
  end
endmodule

// File: rtl/rtc_lp_top.sv
module rtc_lp_top #(
  parameter int ADDR_W = 8,
  parameter int SUB_W  = 15,
  parameter int NFLOPS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [rtc_lp_pkg::DATA_W-1:0] bus_wdata,
  output logic [rtc_lp_pkg::DATA_W-1:0] bus_rdata,
  output logic                         irq
);
  import rtc_lp_pkg::*;

  localparam int CNT_W = DATA_W + SUB_W;
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int CW    = $bits(rtc_ctrl_t);

  rtc_ctrl_t          ctrl_req;
  rtc_ctrl_t          ctrl_act;
  logic [CW-1:0]      ctrl_act_bits;
  logic               act_run, act_arm, act_wake;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  seconds;
  logic [DATA_W-1:0]  alarm_val;
  logic               flag;
  logic [DATA_W-1:0]  hi_word;
  logic [DATA_W-1:0]  ctrl_word;
  logic               sel_ctrl, sel_stat, sel_hi, sel_lo, sel_alarm;

  assign sel_ctrl  = bus_addr == ADDR_W'(OFF_CTRL);
  assign sel_stat  = bus_addr == ADDR_W'(OFF_STAT);
  assign sel_hi    = bus_addr == ADDR_W'(OFF_CNT_HI);
  assign sel_lo    = bus_addr == ADDR_W'(OFF_CNT_LO);
  assign sel_alarm = bus_addr == ADDR_W'(OFF_ALARM);

  // Requested control state, written by software.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_req <= '0;
    end else if (bus_wr && sel_ctrl) begin
      ctrl_req.run  <= bus_wdata[CB_RUN];
      ctrl_req.arm  <= bus_wdata[CB_ARM];
      ctrl_req.wake <= bus_wdata[CB_WAKE];
    end
  end

  rtc_lp_sync #(.W(CW), .NFLOPS(NFLOPS)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .d    (ctrl_req),
    .q    (ctrl_act_bits)
  );

  assign ctrl_act = rtc_ctrl_t'(ctrl_act_bits);
  assign act_run  = ctrl_act.run;
  assign act_arm  = ctrl_act.arm;
  assign act_wake = ctrl_act.wake;

  rtc_lp_counter #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (act_run),
    .ld_lo   (bus_wr && sel_lo),
    .ld_hi   (bus_wr && sel_hi),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .seconds (seconds)
  );

  rtc_lp_alarm #(.DATA_W(DATA_W)) u_alarm (
    .clk       (clk),
    .rst       (rst),
    .seconds   (seconds),
    .arm       (act_arm),
    .wake      (act_wake),
    .ld_alarm  (bus_wr && sel_alarm),
    .clr_flag  (bus_wr && sel_stat && bus_wdata[CB_FLAG]),
    .wdata     (bus_wdata),
    .alarm_val (alarm_val),
    .flag      (flag),
    .irq       (irq)
  );

  // High counter word: pad only when the high part is narrower than a word.
  if (HI_W < DATA_W) begin : g_hi_pad
    assign hi_word = {{(DATA_W-HI_W){1'b0}}, cnt[CNT_W-1:DATA_W]};
  end else begin : g_hi_full
    assign hi_word = cnt[CNT_W-1:DATA_W];
  end

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[CB_RUN]  = act_run;
    ctrl_word[CB_ARM]  = act_arm;
    ctrl_word[CB_WAKE] = act_wake;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (1'b1)
        sel_ctrl:  bus_rdata <= ctrl_word;
        sel_stat:  bus_rdata <= DATA_W'(flag);
        sel_hi:    bus_rdata <= hi_word;
        sel_lo:    bus_rdata <= cnt[DATA_W-1:0];
        sel_alarm: bus_rdata <= alarm_val;
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_lp_checker.sv
module rtc_lp_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 47
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              run,
  input logic              arm,
  input logic              wake,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] alarm_val,
  input logic              flag,
  input logic              irq
);
  import rtc_lp_pkg::*;

  logic cnt_wr, stat_clr, alarm_wr;
  assign cnt_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_CNT_LO) || bus_addr == ADDR_W'(OFF_CNT_HI));
  assign stat_clr = bus_wr && bus_addr == ADDR_W'(OFF_STAT) && bus_wdata[0];
  assign alarm_wr = bus_wr && bus_addr == ADDR_W'(OFF_ALARM);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> cnt == $past(cnt) + CNT_W'(1)); // R3

  AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_wr && !tick) |=> $stable(cnt)); // R4

  AST_ALARM_LOCKED: assert property (@(posedge clk) disable iff (rst)
    arm |=> $stable(alarm_val)); // R5

  AST_ALARM_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!arm && alarm_wr) |=> alarm_val == $past(bus_wdata)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !stat_clr) |=> flag); // R7

  AST_NO_MATCH_DISARMED: assert property (@(posedge clk) disable iff (rst)
    (!flag && !arm) |=> !flag); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && arm && wake)); // R9
endmodule

bind rtc_lp_top rtc_lp_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (rtc_lp_pkg::DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .run       (act_run),
  .arm       (act_arm),
  .wake      (act_wake),
  .cnt       (cnt),
  .alarm_val (alarm_val),
  .flag      (flag),
  .irq       (irq)
);

// File: tb/rtc_lp_top_test.sv
`timescale 1ns/1ps
module rtc_lp_top_test;
  localparam logic [7:0] A_CTRL = 8'h04, A_STAT = 8'h18, A_HI = 8'h1C,
                         A_LO = 8'h20, A_ALARM = 8'h24;

  // {seconds written, expected high register, expected low register}
  localparam logic [95:0] TAB [6] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'h0000_0000, 32'h0000_8000},
    {32'hFFFF_FFFF, 32'h0000_7FFF, 32'hFFFF_8000},
    {32'h8000_0000, 32'h0000_4000, 32'h0000_0000},
    {32'h1234_5678, 32'h0000_091A, 32'h2B3C_0000},
    {32'h0001_FFFF, 32'h0000_0000, 32'hFFFF_8000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rtc_lp_top uut (
    .clk (clk), .rst (rst), .tick (tick), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n, input int gap);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic set_ctrl(input logic [31:0] d);
    wr(A_CTRL, d);
    ticks(3, 0);
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] base, prev, v;
    logic [31:0] h1, l1, h2, l2;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state, stopped counter
    check("R1 irq", {31'b0, irq}, 32'h0);
    expect_rd("R1 ctrl", A_CTRL, 32'h0);
    expect_rd("R1 status", A_STAT, 32'h0);
    expect_rd("R1 hi", A_HI, 32'h0);
    expect_rd("R1 alarm", A_ALARM, 32'h0);
    ticks(2, 0);
    expect_rd("R1 lo after ticks", A_LO, 32'h0);

    // R3 / R4: time loads while stopped, table driven
    for (int i = 0; i < 6; i++) begin
      wr(A_LO, TAB[i][63:32] == TAB[i][63:32] ? TAB[i][95:64] << 15 : 32'h0);
      wr(A_HI, TAB[i][95:64] >> 17);
      expect_rd("R3 table hi", A_HI, TAB[i][63:32]);
      expect_rd("R3 table lo", A_LO, TAB[i][31:0]);
    end

    // R2: three-tick staging of the run bit
    wr(A_CTRL, 32'h1);
    ticks(2, 0);
    expect_rd("R2 run not yet in effect", A_CTRL, 32'h0);
    ticks(1, 0);
    expect_rd("R2 run in effect", A_CTRL, 32'h1);

    // R4: loads ignored while running
    wr(A_LO, 32'h0000_DEAD);
    wr(A_HI, 32'h7);
    expect_rd("R4 lo unchanged", A_LO, 32'hFFFF_8000);
    expect_rd("R4 hi unchanged", A_HI, 32'h0);
    ticks(2, 0);
    expect_rd("R3 two ticks", A_LO, 32'hFFFF_8002);

    // R3: carry from low word into high register
    set_ctrl(32'h0);
    wr(A_LO, 32'hFFFF_FFFD);
    wr(A_HI, 32'h0);
    set_ctrl(32'h1);
    ticks(2, 0);
    expect_rd("R3 before carry lo", A_LO, 32'hFFFF_FFFF);
    expect_rd("R3 before carry hi", A_HI, 32'h0);
    ticks(2, 0);
    expect_rd("R3 after carry hi", A_HI, 32'h1);
    expect_rd("R3 after carry lo", A_LO, 32'h1);

    // R5 / R6: alarm one second ahead
    set_ctrl(32'h0);
    wr(A_ALARM, 32'h0002_0001);
    expect_rd("R5 alarm load", A_ALARM, 32'h0002_0001);
    wr(A_LO, 32'h0000_7FF8);
    set_ctrl(32'hB);
    expect_rd("R2 all bits", A_CTRL, 32'hB);
    wr(A_ALARM, 32'h0000_5555);
    expect_rd("R5 alarm locked", A_ALARM, 32'h0002_0001);
    ticks(7, 0);
    idle(2);
    expect_rd("R6 one second early", A_STAT, 32'h0);
    check("R9 irq early", {31'b0, irq}, 32'h0);
    ticks(1, 0);
    idle(2);
    check("R9 irq on match", {31'b0, irq}, 32'h1);
    expect_rd("R6 match flag", A_STAT, 32'h1);

    // R7 / R8 / R9: disarm, sticky flag, clears
    set_ctrl(32'h9);
    idle(2);
    check("R9 irq disarmed", {31'b0, irq}, 32'h0);
    expect_rd("R7 sticky", A_STAT, 32'h1);
    wr(A_STAT, 32'h0);
    expect_rd("R7 write zero", A_STAT, 32'h1);
    wr(A_STAT, 32'hFFFF_FFFF);
    expect_rd("R7 clear all ones", A_STAT, 32'h0);
    idle(3);
    expect_rd("R8 no match when disarmed", A_STAT, 32'h0);

    // R9: armed without wake-up
    set_ctrl(32'h3);
    idle(2);
    expect_rd("R6 rearmed match", A_STAT, 32'h1);
    check("R9 no wake", {31'b0, irq}, 32'h0);
    wr(A_STAT, 32'h1);
    expect_rd("R7 match wins over clear", A_STAT, 32'h1);
    set_ctrl(32'hB);
    idle(2);
    check("R9 wake enabled", {31'b0, irq}, 32'h1);
    set_ctrl(32'h1);
    wr(A_STAT, 32'h1);

    // R10: double-read consistency across a low-word carry
    set_ctrl(32'h0);
    wr(A_LO, 32'hFFFF_FFE0);
    wr(A_HI, 32'h5);
    set_ctrl(32'h1);
    base = 64'h5_FFFF_FFE0;
    prev = base;
    fork
      ticks(64, 12);
      begin
        for (int k = 0; k < 12; k++) begin
          int tries;
          idle(40);
          tries = 0;
          do begin
            rd(A_HI, h1); rd(A_LO, l1); rd(A_HI, h2); rd(A_LO, l2);
            tries++;
          end while ((h1 != h2 || l1 != l2) && tries < 20);
          v = {h1, l1};
          n_chk++;
          if (h1 != h2 || l1 != l2 || v < prev || v > base + 64) begin
            n_bad++;
            $display("FAIL R10 read %0d: got %h expected in [%h,%h]", k, v, prev, base + 64);
          end
          prev = v;
        end
      end
    join
    expect_rd("R3 final hi", A_HI, 32'h6);
    expect_rd("R3 final lo", A_LO, 32'h20);

    finish_run();
  end
endmodule